// File: doc/BRIEF.md
# Compare-and-Reconnect Audio Sequencer

This block rejoins a stereo sample stream after it was interrupted. The host first loads the last three stored left/right pairs as the reference. It then issues a start command. The block watches the freshly re-read 16-bit words and slides a three-pair window over them, one stereo pair at a time. When the window lines up with the reference, the block emits a one-cycle connect pulse. It also raises an encode-restart request, which tells the writer to resume at the validated write pointer. The same pulse stands for clearing the "encoding halted internally" condition.

There are three modes. The strict mode needs all three pairs to match. The tolerant mode needs two of the three. The direct mode makes no comparison and connects once three aligned words have arrived. An optional 12-bit compare ignores the low four bits of every word.

The first start after reset waits for a preparation interval before any word is compared. A later start skips this interval. The sample input follows valid/ready rules, and `in_ready` is held high at all times, so the block never applies back-pressure. A word counts only in the cycle where `in_valid` is high. Words that arrive while the block is idle, while it is preparing, or in a cycle that carries a command are consumed and dropped.

Top module: `rcn_seq`

## Requirements
- R1: After reset, `busy`, `connect` and `enc_restart` are low, and no preparation is marked as done.
- R2: A command (`cmd_valid` high) is decoded from `cmd_code` as follows. Code 2'b11 starts the strict 3-pair compare. Code 2'b10 starts the 2-of-3 compare. Code 2'b01 starts a direct connect. Any start sets `busy` from the next cycle. Code 2'b00 stops the sequence and clears `busy`. When the block is idle, code 2'b00 changes nothing.
- R3: The first start after reset waits `PREP_CYC` clock cycles before it accepts words for comparison. Words that arrive during this wait are dropped and cannot cause a connect.
- R4: A start issued after one preparation has completed begins comparing in the next cycle, with no wait.
- R5: Alignment is kept by `in_left` (1 = left word). A pair is formed by a left word followed by a right word. A right word with no pending left word is dropped. A second left word replaces the pending left word. Every start clears the window.
- R6: In 3-pair mode, `connect` fires one cycle after the right word that makes the three most recent pairs equal to the reference pairs 0, 1 and 2, in order. The window slides by one pair for each completed pair.
- R7: In 2-of-3 mode, `connect` fires when at least two of the three window positions equal their reference pair. A position matches only if both its left and right words match.
- R8: In direct mode, no comparison is made. `connect` fires one cycle after the third aligned word. Aligned words are left words and right words that complete a pair.
- R9: While `cmp12` is high, bits [3:0] of every word are ignored in the comparison. The input is sampled live, so a change in the middle of a sequence applies to the next pair that completes.
- R10: `cmd_enc_en` marks a command that also enables encoding. With code 2'b00, such a command clears `busy`. With a start code, the start takes priority and `busy` stays set.
- R11: `connect` lasts exactly one cycle, and `busy` falls in the same cycle. `enc_restart` rises with `connect`. It stays high until a start command arrives, or a stop command arrives with `cmd_enc_en` low.
- R12: The reference is loaded with `ref_we`, `ref_idx` and `ref_data`. An even index is a left word and an odd index is a right word. Indices 0/1 are the oldest pair (reference pair 0) and indices 4/5 are the newest pair (reference pair 2). Indices 6 and 7 are ignored.
- R13: `in_ready` is high in every cycle after reset. A word offered outside the compare phase, or in a cycle with `cmd_valid` high, has no effect on the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 2 | Start/stop code |
| cmd_enc_en | input | 1 | Encode-enable carried with the command |
| cmp12 | input | 1 | Ignore the low 4 bits of each word in comparison |
| ref_we | input | 1 | Reference word write strobe |
| ref_idx | input | 3 | Reference word index |
| ref_data | input | 16 | Reference word value |
| in_valid | input | 1 | Sample word valid |
| in_ready | output | 1 | Always high; the block accepts every word |
| in_left | input | 1 | 1 = left-channel word |
| in_data | input | 16 | Sample word |
| busy | output | 1 | Sequence preparing or comparing |
| connect | output | 1 | One-cycle pulse: connection found |
| enc_restart | output | 1 | Request to resume encoding at the validated pointer |

## Verification
The assertions assume that commands are single-cycle strobes and that `cmd_code` is stable while `cmd_valid` is high. They also assume that `in_valid` can be high in any cycle, including cycles that carry a command, because the ready signal never drops. The stimulus drives every input on the falling clock edge and holds each command or word for exactly one cycle. It never loads the reference while a sequence is comparing, so the window always meets a stable reference.

// File: rtl/rcn_pkg.sv
package rcn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_CMP  = 2'd2
  } rcn_state_e;

  typedef enum logic [1:0] {
    CM_STOP   = 2'b00,
    CM_DIRECT = 2'b01,
    CM_TWO    = 2'b10,
    CM_THREE  = 2'b11
  } rcn_cmd_e;

  function automatic logic is_start(input logic [1:0] code);
    return code != CM_STOP;
  endfunction
endpackage

// File: rtl/rcn_prep_timer.sv
module rcn_prep_timer #(
  parameter int PREP_CYC = 960
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int PW = $clog2(PREP_CYC + 1);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == PW'(PREP_CYC - 1));
endmodule

// File: rtl/rcn_ref_bank.sv
module rcn_ref_bank #(
  parameter int DW    = 16,
  parameter int NPAIR = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [$clog2(2*NPAIR)-1:0]   idx,
  input  logic [DW-1:0]                data,
  output logic [NPAIR-1:0][DW-1:0]     ref_l,
  output logic [NPAIR-1:0][DW-1:0]     ref_r
);
  localparam int IW = $clog2(2*NPAIR);

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_l[k] <= '0;
        ref_r[k] <= '0;
      end else if (we) begin
        if (idx == IW'(2*k))     ref_l[k] <= data;
        if (idx == IW'(2*k + 1)) ref_r[k] <= data;
      end
    end
  end
endmodule

// File: rtl/rcn_pair_window.sv
module rcn_pair_window #(
  parameter int DW    = 16,
  parameter int NPAIR = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     take,
  input  logic                     is_left,
  input  logic [DW-1:0]            data,
  output logic [NPAIR-1:0][DW-1:0] cand_l,
  output logic [NPAIR-1:0][DW-1:0] cand_r,
  output logic                     pair_fire,
  output logic                     third_word
);
  localparam int CW = $clog2(NPAIR + 1);

  logic [NPAIR-1:0][DW-1:0] win_l, win_r;
  logic [DW-1:0]            pend_q;
  logic                     have_l;
  logic [CW-1:0]            pcnt_q;
  logic [1:0]               wcnt_q;
  logic                     aligned, completes;

  assign completes = take && !is_left && have_l;
  assign aligned   = take && (is_left || have_l);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pend_q <= '0;
      have_l <= 1'b0;
      pcnt_q <= '0;
      wcnt_q <= '0;
    end else begin
      if (aligned && wcnt_q != 2'd3) wcnt_q <= wcnt_q + 2'd1;
      if (take && is_left) begin
        pend_q <= data;
        have_l <= 1'b1;
      end else if (completes) begin
        have_l <= 1'b0;
        if (pcnt_q != CW'(NPAIR)) pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_slot
    if (i < NPAIR - 1) begin : g_mid
      assign cand_l[i] = win_l[i+1];
      assign cand_r[i] = win_r[i+1];
    end else begin : g_new
      assign cand_l[i] = pend_q;
      assign cand_r[i] = data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        win_l[i] <= '0;
        win_r[i] <= '0;
      end else if (completes) begin
        win_l[i] <= cand_l[i];
        win_r[i] <= cand_r[i];
      end
    end
  end

  assign pair_fire  = completes && (pcnt_q >= CW'(NPAIR - 1));
  assign third_word = aligned && (wcnt_q == 2'd2);
endmodule

// File: rtl/rcn_match_eval.sv
module rcn_match_eval #(
  parameter int DW      = 16,
  parameter int NPAIR   = 3,
  parameter int LOWBITS = 4
) (
  input  logic [NPAIR-1:0][DW-1:0] cand_l,
  input  logic [NPAIR-1:0][DW-1:0] cand_r,
  input  logic [NPAIR-1:0][DW-1:0] ref_l,
  input  logic [NPAIR-1:0][DW-1:0] ref_r,
  input  logic                     coarse,
  input  logic                     tolerant,
  output logic                     hit
);
  localparam logic [DW-1:0] FULL_M = '1;
  localparam logic [DW-1:0] COARSE_M = {{(DW-LOWBITS){1'b1}}, {LOWBITS{1'b0}}};

  logic [DW-1:0]    m;
  logic [NPAIR-1:0] eq;

  assign m = coarse ? COARSE_M : FULL_M;

  for (genvar k = 0; k < NPAIR; k++) begin : g_cmp
    assign eq[k] = ((cand_l[k] & m) == (ref_l[k] & m)) &&
                   ((cand_r[k] & m) == (ref_r[k] & m));
  end

  always_comb begin
    if (tolerant) hit = ($countones(eq) >= NPAIR - 1);
    else          hit = &eq;
  end
endmodule

// File: rtl/rcn_seq.sv
module rcn_seq
  import rcn_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NPAIR    = 3,
  parameter int LOWBITS  = 4,
  parameter int PREP_CYC = 960
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_code,
  input  logic                       cmd_enc_en,
  input  logic                       cmp12,
  input  logic                       ref_we,
  input  logic [$clog2(2*NPAIR)-1:0] ref_idx,
  input  logic [DW-1:0]              ref_data,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_left,
  input  logic [DW-1:0]              in_data,
  output logic                       busy,
  output logic                       connect,
  output logic                       enc_restart
);
  rcn_state_e st_q;
  rcn_cmd_e   mode_q;
  logic       prepared_q, conn_q, restart_q, rdy_q;
  logic       start, stop, take, prep_done, fire, hit, pair_fire, third_word;
  logic [NPAIR-1:0][DW-1:0] ref_l, ref_r, cand_l, cand_r;

  assign start = cmd_valid && is_start(cmd_code);
  assign stop  = cmd_valid && !is_start(cmd_code);
  assign take  = in_valid && (st_q == ST_CMP) && !cmd_valid;

  rcn_ref_bank #(.DW(DW), .NPAIR(NPAIR)) u_ref (
    .clk(clk), .rst_n(rst_n), .we(ref_we), .idx(ref_idx), .data(ref_data),
    .ref_l(ref_l), .ref_r(ref_r)
  );

  rcn_prep_timer #(.PREP_CYC(PREP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(start), .run(st_q == ST_PREP && !cmd_valid),
    .done(prep_done)
  );

  rcn_pair_window #(.DW(DW), .NPAIR(NPAIR)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(start), .take(take), .is_left(in_left),
    .data(in_data), .cand_l(cand_l), .cand_r(cand_r),
    .pair_fire(pair_fire), .third_word(third_word)
  );

  rcn_match_eval #(.DW(DW), .NPAIR(NPAIR), .LOWBITS(LOWBITS)) u_eval (
    .cand_l(cand_l), .cand_r(cand_r), .ref_l(ref_l), .ref_r(ref_r),
    .coarse(cmp12), .tolerant(mode_q == CM_TWO), .hit(hit)
  );

  always_comb begin
    if (mode_q == CM_DIRECT) fire = third_word;
    else                     fire = pair_fire && hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mode_q     <= CM_STOP;
      prepared_q <= 1'b0;
      conn_q     <= 1'b0;
      restart_q  <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
      conn_q <= 1'b0;
      if (start) begin
        st_q      <= prepared_q ? ST_CMP : ST_PREP;
        mode_q    <= rcn_cmd_e'(cmd_code);
        restart_q <= 1'b0;
      end else if (stop) begin
        st_q <= ST_IDLE;
        if (!cmd_enc_en) restart_q <= 1'b0;
      end else if (st_q == ST_PREP && prep_done) begin
        st_q       <= ST_CMP;
        prepared_q <= 1'b1;
      end else if (st_q == ST_CMP && fire) begin
        st_q      <= ST_IDLE;
        conn_q    <= 1'b1;
        restart_q <= 1'b1;
      end
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign connect     = conn_q;
  assign enc_restart = restart_q;
  assign in_ready    = rdy_q;
endmodule

// File: rtl/rcn_seq_chk.sv
module rcn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic       cmd_enc_en,
  input logic       in_valid,
  input logic       busy,
  input logic       connect,
  input logic       enc_restart
);
  // R11
  connect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    connect |=> !connect);
  // R11
  connect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    connect |-> !busy);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != 2'b00) |=> busy);
  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'b00) |=> !busy);
  // R2
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_code != 2'b00)) |=> !busy);
  // R11
  restart_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_restart) |-> connect);
  // R11
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_restart && !cmd_valid) |=> enc_restart);
  // R10
  enc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_enc_en && cmd_code == 2'b00 && enc_restart) |=> enc_restart);
  // R13
  connect_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect) |-> $past(in_valid));
endmodule

bind rcn_seq rcn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_enc_en(cmd_enc_en), .in_valid(in_valid), .busy(busy),
  .connect(connect), .enc_restart(enc_restart)
);

// File: tb/rcn_seq_test.sv
`timescale 1ns/1ps
module rcn_seq_test;
  localparam int PC = 40;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_enc_en = 0, cmp12 = 0, ref_we = 0;
  logic [1:0] cmd_code = 0;
  logic [2:0] ref_idx = 0;
  logic [15:0] ref_data = 0, in_data = 0;
  logic in_valid = 0, in_left = 0;
  logic in_ready, busy, connect, enc_restart;

  always #2.5 clk = ~clk;

  rcn_seq #(.PREP_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_enc_en(cmd_enc_en), .cmp12(cmp12), .ref_we(ref_we), .ref_idx(ref_idx),
    .ref_data(ref_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_data(in_data), .busy(busy), .connect(connect),
    .enc_restart(enc_restart)
  );

  int total = 0, bad = 0;
  logic [15:0] r_l[3], r_r[3], bw_l[3], bw_r[3], bpend;
  bit bhave, bactive, bc12;
  int bpc, bwc, bmode;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit eqw(logic [15:0] a, logic [15:0] b);
    return bc12 ? (a[15:4] == b[15:4]) : (a == b);
  endfunction

  task automatic model_start(int mode);
    bmode = mode; bhave = 0; bpc = 0; bwc = 0;
  endtask

  task automatic model_word(bit l, logic [15:0] d, output bit exp);
    int n;
    exp = 0;
    if (!bactive) return;
    if (l) begin
      if (bmode == 1 && bwc == 2) exp = 1;
      if (bwc < 3) bwc++;
      bpend = d; bhave = 1;
    end else if (bhave) begin
      if (bmode == 1 && bwc == 2) exp = 1;
      if (bwc < 3) bwc++;
      for (int i = 0; i < 2; i++) begin bw_l[i] = bw_l[i+1]; bw_r[i] = bw_r[i+1]; end
      bw_l[2] = bpend; bw_r[2] = d; bhave = 0;
      if (bpc < 3) bpc++;
      if (bmode != 1 && bpc == 3) begin
        n = 0;
        for (int k = 0; k < 3; k++) if (eqw(bw_l[k], r_l[k]) && eqw(bw_r[k], r_r[k])) n++;
        exp = (bmode == 3) ? (n == 3) : (n >= 2);
      end
    end
    if (exp) bactive = 0;
  endtask

  task automatic cmd(logic [1:0] code, bit en);
    @(negedge clk); cmd_valid = 1; cmd_code = code; cmd_enc_en = en;
    @(negedge clk); cmd_valid = 0; cmd_enc_en = 0;
  endtask

  task automatic start(logic [1:0] code, bit en, bit prep_due);
    cmd(code, en);
    model_start(code == 2'b11 ? 3 : code == 2'b10 ? 2 : 1);
    bactive = !prep_due;
  endtask

  task automatic word(string tag, bit l, logic [15:0] d, output bit got);
    bit exp;
    @(negedge clk); in_valid = 1; in_left = l; in_data = d;
    model_word(l, d, exp);
    @(negedge clk); in_valid = 0;
    got = connect;
    check(tag, connect, exp);
  endtask

  task automatic pair(string tag, logic [15:0] l, logic [15:0] r, output bit got);
    bit g;
    word(tag, 1, l, g);
    word(tag, 0, r, got);
    got = got | g;
  endtask

  task automatic load_ref();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ref_we = 1; ref_idx = 3'(i); ref_data = 16'($urandom);
      if (i % 2 == 0) r_l[i/2] = ref_data; else r_r[i/2] = ref_data;
    end
    @(negedge clk); ref_we = 1; ref_idx = 3'd6; ref_data = 16'hDEAD;
    @(negedge clk); ref_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit g;
    void'($urandom(32'h5EED));
    bactive = 0; bc12 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    // R1 / R13
    check("R1 busy", busy, 0);
    check("R1 connect", connect, 0);
    check("R1 enc_restart", enc_restart, 0);
    check("R13 in_ready", in_ready, 1);
    load_ref();  // R12 layout; index 6 write must not disturb matching

    cmd(2'b00, 0);
    check("R2 stop when idle", busy, 0);

    start(2'b11, 0, 1);
    check("R2 start busy", busy, 1);
    for (int k = 0; k < 3; k++) pair("R3 ignored during prep", r_l[k], r_r[k], g);
    check("R3 still busy", busy, 1);
    repeat (PC) @(negedge clk);
    bactive = 1;
    word("R5 lone right dropped", 0, r_r[0], g);
    word("R5 left replaced", 1, 16'h1234, g);
    for (int k = 0; k < 3; k++) pair("R6 three-pair match", r_l[k], r_r[k], g);
    check("R6 connected", g, 1);
    check("R11 busy drops", busy, 0);
    check("R11 restart high", enc_restart, 1);
    @(negedge clk);
    check("R11 connect one cycle", connect, 0);

    cmd(2'b00, 1);
    check("R11 restart kept by enc stop", enc_restart, 1);
    start(2'b10, 0, 0);
    check("R11 restart cleared by start", enc_restart, 0);
    pair("R4 no prep", r_l[0], r_r[0], g);
    pair("R7 two-of-three", ~r_l[1], r_r[1], g);
    pair("R7 two-of-three", r_l[2], r_r[2], g);
    check("R7 connected", g, 1);

    start(2'b11, 0, 0);
    pair("R6 slide", 16'h0F0F, 16'hF0F0, g);
    for (int k = 0; k < 3; k++) pair("R6 slide", r_l[k], r_r[k], g);
    check("R6 slide connected", g, 1);

    cmp12 = 1; bc12 = 1;
    start(2'b11, 0, 0);
    for (int k = 0; k < 3; k++) pair("R9 coarse match", r_l[k] ^ 16'h000F, r_r[k] ^ 16'h0005, g);
    check("R9 coarse connected", g, 1);
    @(negedge clk); cmp12 = 0; bc12 = 0;
    start(2'b11, 0, 0);
    for (int k = 0; k < 3; k++) pair("R9 full compare", r_l[k] ^ 16'h0001, r_r[k], g);
    check("R9 no match full", busy, 1);
    @(negedge clk); cmp12 = 1; bc12 = 1;
    for (int k = 0; k < 3; k++) pair("R9 live switch", r_l[k] ^ 16'h0001, r_r[k], g);
    check("R9 live switch connected", g, 1);
    @(negedge clk); cmp12 = 0; bc12 = 0;

    start(2'b01, 0, 0);
    word("R8 lone right", 0, 16'h0, g);
    word("R8 first", 1, 16'h1, g);
    word("R8 second", 0, 16'h2, g);
    check("R8 not yet", busy, 1);
    word("R8 third", 1, 16'h3, g);
    check("R8 direct connected", g, 1);

    start(2'b11, 0, 0);
    cmd(2'b00, 0);
    check("R2 stop clears busy", busy, 0);
    start(2'b11, 1, 0);
    check("R10 start wins over enc", busy, 1);
    cmd(2'b00, 1);
    check("R10 enc clears busy", busy, 0);

    for (int it = 0; it < 150; it++) begin
      int m;
      if (it % 10 == 0) load_ref();
      cmp12 = 1'($urandom); bc12 = cmp12;
      m = $urandom % 3;
      start(m == 0 ? 2'b11 : m == 1 ? 2'b10 : 2'b01, 1'($urandom), 0);
      for (int p = 0; p < 10 && busy; p++) begin
        logic [15:0] a, b;
        if ($urandom % 10 < 6) begin
          a = r_l[p % 3] ^ (bc12 ? 16'($urandom % 16) : 16'h0);
          b = r_r[p % 3];
        end else begin
          a = 16'($urandom); b = 16'($urandom);
        end
        if ($urandom % 8 == 0) word("R5 random glitch", 0, a, g);
        if (busy) pair("R6 R7 R8 random stream", a, b, g);
      end
      if (busy) begin
        cmd(2'b00, 0);
        check("R2 random stop", busy, 0);
      end
      bactive = 0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule